// File: doc/BRIEF.md
# Secure Physical Timer Compare Unit

This unit holds the compare side of a secure physical timer. A free-running 64-bit count arrives as an input and is compared every cycle against a stored 64-bit compare value. Software reaches the unit through system-register accesses. Each access carries a 16-bit register identifier, a read/write flag, write data, the current privilege level and the security context. Software can see the timer in three ways:

- a control word, with enable, mask and a read-only status;
- the absolute compare value;
- a signed 32-bit relative view, computed as the distance from the live count to the compare value.

Each access receives exactly one registered response one cycle later. The response is one of three outcomes: permitted, undefined, or a trap to the monitor level with a syndrome class. Read data comes with the response. A level-sensitive interrupt output follows the timer condition and is gated by the mask bit.

The relative view is not a stored down-counter. A read subtracts the live count from the compare value. A write turns the signed 32-bit value into an absolute compare value. Because of this, the relative view keeps counting down while the timer is disabled, since the count keeps advancing.

Top module: `sec_timer_cmp`

## Requirements
- R1: After a synchronous reset, enable is 0, mask is 1, the compare value is 0, no response is valid and the interrupt is low.
- R2: The register identifier is {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}, with op0 at the top. op0=3, op1=7, CRn=14, CRm=2 select the unit's registers: op2=0 is the relative view, op2=1 is the control word, op2=2 is the compare value. Any other identifier is undefined.
- R3: Accesses at privilege level 0 or level 2 are undefined, and accesses at level 3 are permitted.
- R4: At level 1, if the monitor level exists and the state is secure, the outcome is decided in this order: a set secure-level-2 enable gives undefined; otherwise a clear secure-timer-access bit gives a trap; otherwise the access is permitted. Every other level-1 access is undefined.
- R5: An undefined or trapped access changes no state and returns read data of zero.
- R6: The response is valid exactly one cycle after the request. Its kind is encoded 0=permitted, 1=undefined, 2=trap. The syndrome is 0x18 on a trap and 0 otherwise. A permitted write returns read data of zero.
- R7: A read of the relative view returns the low 32 bits of (compare − count), zero-extended to 64 bits. This holds whether or not the timer is enabled, so the value keeps falling as the count advances.
- R8: A write to the relative view sets the compare value to count + the sign-extended write data bits 31:0. Write data bits 63:32 are ignored.
- R9: The timer condition holds when enable is 1 and (count − compare), taken as a signed 64-bit value, is zero or positive. The control word reads enable at bit 0, mask at bit 1 and the condition at bit 2, with all other bits zero.
- R10: The interrupt output is high in the cycle after the condition holds with mask at 0, and low otherwise.
- R11: A write to the control word updates only enable and mask. Writes to the status bit have no effect.
- R12: The compare value is read and written as a full 64-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 64 | Free-running system count |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_id_i | input | 16 | Encoded system-register identifier |
| req_wdata_i | input | 64 | Write data |
| priv_lvl_i | input | 2 | Current privilege level 0..3 |
| mon_present_i | input | 1 | Monitor level 3 is implemented |
| secure_i | input | 1 | Current security state is secure |
| sec_l2_en_i | input | 1 | Secure level 2 is enabled |
| sec_timer_acc_i | input | 1 | Level-1 access to the secure timer is allowed |
| rsp_valid_o | output | 1 | Response valid |
| rsp_kind_o | output | 2 | 0 permitted, 1 undefined, 2 trap |
| rsp_syn_o | output | 6 | Syndrome class for a trap |
| rsp_rdata_o | output | 64 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the case where the count has wrapped ahead of a compare value of zero. An unsigned comparison would wrongly fire there. It checks a relative-view write of 0x80000000: a design that zero-extends the value instead of sign-extending it would place the compare value 4 GiB too far ahead. It also checks a write whose upper bits are set, which would corrupt the compare value if those bits were honoured. Further tests exercise each level-1 branch of the access decision. A wrong branch order would show up as a trap instead of undefined, or as a trapped write that still lands. Other tests cover a status write that must not stick, a mask that must silence the interrupt while status stays set, and a relative view that must keep falling while the timer is disabled.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

  localparam int unsigned ID_W = 16;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_UNDEF = 2'd1,
    RSP_TRAP  = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CMP,
    SEL_TVAL
  } reg_sel_e;

  // identifier layout {op0, op1, CRn, CRm, op2}
  localparam logic [12:0] ID_BASE  = {2'b11, 3'b111, 4'b1110, 4'b0010};
  localparam logic [2:0]  OP2_TVAL = 3'd0;
  localparam logic [2:0]  OP2_CTRL = 3'd1;
  localparam logic [2:0]  OP2_CMP  = 3'd2;

  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_STAT = 2;

  localparam logic [1:0] LVL0 = 2'd0;
  localparam logic [1:0] LVL1 = 2'd1;
  localparam logic [1:0] LVL2 = 2'd2;
  localparam logic [1:0] LVL3 = 2'd3;

endpackage

// File: rtl/sec_timer_access.sv
module sec_timer_access
  import sec_timer_pkg::*;
(
  input  logic [ID_W-1:0] id_i,
  input  logic [1:0]      lvl_i,
  input  logic            mon_present_i,
  input  logic            secure_i,
  input  logic            sec_l2_en_i,
  input  logic            sec_timer_acc_i,
  output reg_sel_e        sel_o,
  output rsp_kind_e       kind_o
);

  logic [12:0] id_base;
  logic [2:0]  id_op2;

  assign id_base = id_i[ID_W-1:3];
  assign id_op2  = id_i[2:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (id_base == ID_BASE) begin
      case (id_op2)
        OP2_TVAL: sel_o = SEL_TVAL;
        OP2_CTRL: sel_o = SEL_CTRL;
        OP2_CMP:  sel_o = SEL_CMP;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    kind_o = RSP_UNDEF;
    if (sel_o != SEL_NONE) begin
      case (lvl_i)
        LVL3: kind_o = RSP_OK;
        LVL1: begin
          if (mon_present_i && secure_i) begin
            if (sec_l2_en_i)           kind_o = RSP_UNDEF;
            else if (!sec_timer_acc_i) kind_o = RSP_TRAP;
            else                       kind_o = RSP_OK;
          end
        end
        default: kind_o = RSP_UNDEF;
      endcase
    end
  end

endmodule

// File: rtl/sec_timer_core.sv
module sec_timer_core
  import sec_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             en_o,
  output logic             mask_o,
  output logic             irq_o
);

  localparam int unsigned EXT_W = CNT_W - TV_W;

  logic             en_q;
  logic             mask_q;
  logic [CNT_W-1:0] cmp_q;
  logic             irq_q;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] tval_sext;
  logic             cond;

  assign elapsed   = count_i - cmp_q;
  assign remain    = cmp_q - count_i;
  assign tval_sext = {{EXT_W{wdata_i[TV_W-1]}}, wdata_i[TV_W-1:0]};
  assign cond      = en_q && !elapsed[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mask_q <= 1'b1;
      cmp_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= cond && !mask_q;
      if (wr_en_i) begin
        case (sel_i)
          SEL_CTRL: begin
            en_q   <= wdata_i[CTL_EN];
            mask_q <= wdata_i[CTL_MASK];
          end
          SEL_CMP:  cmp_q <= wdata_i;
          SEL_TVAL: cmp_q <= count_i + tval_sext;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_CTRL: begin
        rdata_o[CTL_EN]   = en_q;
        rdata_o[CTL_MASK] = mask_q;
        rdata_o[CTL_STAT] = cond;
      end
      SEL_CMP:  rdata_o = cmp_q;
      SEL_TVAL: rdata_o = {{EXT_W{1'b0}}, remain[TV_W-1:0]};
      default:  rdata_o = '0;
    endcase
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/sec_timer_rsp.sv
module sec_timer_rsp
  import sec_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SYN_W   = 6,
  parameter int unsigned TRAP_EC = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  rsp_kind_e         kind_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_kind_o,
  output logic [SYN_W-1:0]  rsp_syn_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  localparam logic [SYN_W-1:0] EC_VAL = SYN_W'(TRAP_EC);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= RSP_OK;
      rsp_syn_o   <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_kind_o  <= kind_i;
        rsp_syn_o   <= (kind_i == RSP_TRAP) ? EC_VAL : '0;
        rsp_rdata_o <= (kind_i == RSP_OK && !req_write_i) ? rdata_i : '0;
      end
    end
  end

endmodule

// File: rtl/sec_timer_cmp.sv
module sec_timer_cmp
  import sec_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned TV_W    = 32,
  parameter int unsigned SYN_W   = 6,
  parameter int unsigned TRAP_EC = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [15:0]      req_id_i,
  input  logic [CNT_W-1:0] req_wdata_i,
  input  logic [1:0]       priv_lvl_i,
  input  logic             mon_present_i,
  input  logic             secure_i,
  input  logic             sec_l2_en_i,
  input  logic             sec_timer_acc_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_kind_o,
  output logic [SYN_W-1:0] rsp_syn_o,
  output logic [CNT_W-1:0] rsp_rdata_o,
  output logic             irq_o
);

  reg_sel_e         sel;
  rsp_kind_e        kind;
  logic             wr_en;
  logic [CNT_W-1:0] core_rdata;
  logic [CNT_W-1:0] cmp_val;
  logic             ctrl_en;
  logic             ctrl_mask;

  assign wr_en = req_valid_i && req_write_i && (kind == RSP_OK);

  sec_timer_access i_access (
    .id_i            (req_id_i),
    .lvl_i           (priv_lvl_i),
    .mon_present_i   (mon_present_i),
    .secure_i        (secure_i),
    .sec_l2_en_i     (sec_l2_en_i),
    .sec_timer_acc_i (sec_timer_acc_i),
    .sel_o           (sel),
    .kind_o          (kind)
  );

  sec_timer_core #(
    .CNT_W (CNT_W),
    .TV_W  (TV_W)
  ) i_core (
    .clk     (clk),
    .rst     (rst),
    .count_i (count_i),
    .wr_en_i (wr_en),
    .sel_i   (sel),
    .wdata_i (req_wdata_i),
    .rdata_o (core_rdata),
    .cmp_o   (cmp_val),
    .en_o    (ctrl_en),
    .mask_o  (ctrl_mask),
    .irq_o   (irq_o)
  );

  sec_timer_rsp #(
    .DATA_W  (CNT_W),
    .SYN_W   (SYN_W),
    .TRAP_EC (TRAP_EC)
  ) i_rsp (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .kind_i      (kind),
    .rdata_i     (core_rdata),
    .rsp_valid_o (rsp_valid_o),
    .rsp_kind_o  (rsp_kind_o),
    .rsp_syn_o   (rsp_syn_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

endmodule

// File: rtl/sec_timer_cmp_chk.sv
module sec_timer_cmp_chk
  import sec_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SYN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [15:0]      req_id_i,
  input logic [1:0]       priv_lvl_i,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_kind_o,
  input logic [SYN_W-1:0] rsp_syn_o,
  input logic [CNT_W-1:0] rsp_rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cmp_val,
  input logic             ctrl_en,
  input logic             ctrl_mask
);

  localparam logic [15:0] ID_TV = {ID_BASE, OP2_TVAL};

  p_rsp_follows_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> rsp_valid_o);

  p_rsp_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !rsp_valid_o);

  p_trap_syn_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_kind_o == RSP_TRAP) |-> rsp_syn_o == 6'h18);

  p_block_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_kind_o != RSP_OK) |-> rsp_rdata_o == '0);

  p_lvl0_undef_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && priv_lvl_i == LVL0) |=> rsp_kind_o == RSP_UNDEF);

  p_lvl3_ok_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && priv_lvl_i == LVL3 && req_id_i == ID_TV) |=> rsp_kind_o == RSP_OK);

  p_block_nochg_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_write_i && (priv_lvl_i == LVL0 || priv_lvl_i == LVL2))
      |=> $stable(cmp_val));

  p_tval_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_write_i && priv_lvl_i == LVL3 && req_id_i == ID_TV)
      |=> rsp_rdata_o[CNT_W-1:32] == '0);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_en && !ctrl_mask));

endmodule

bind sec_timer_cmp sec_timer_cmp_chk #(
  .CNT_W (CNT_W),
  .SYN_W (SYN_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_id_i    (req_id_i),
  .priv_lvl_i  (priv_lvl_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_kind_o  (rsp_kind_o),
  .rsp_syn_o   (rsp_syn_o),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_o       (irq_o),
  .cmp_val     (cmp_val),
  .ctrl_en     (ctrl_en),
  .ctrl_mask   (ctrl_mask)
);

// File: tb/test_sec_timer_cmp.sv
`timescale 1ns/1ps
module test_sec_timer_cmp;

  localparam logic [15:0] ID_TV  = 16'b11_111_1110_0010_000;
  localparam logic [15:0] ID_CTL = 16'b11_111_1110_0010_001;
  localparam logic [15:0] ID_CMP = 16'b11_111_1110_0010_010;
  localparam logic [15:0] ID_BAD = 16'b11_111_1110_0011_000;

  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] count = '0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_id = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  lvl = 2'd3;
  logic        mon = 1, sec = 1, sl2 = 0, stacc = 1;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [5:0]  rsp_syn;
  logic [63:0] rsp_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [1:0]  r_kind;
  logic [5:0]  r_syn;
  logic [63:0] r_data;
  logic        r_valid;

  always #10 clk = ~clk;

  sec_timer_cmp i_sec_timer_cmp (
    .clk(clk), .rst(rst), .count_i(count),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_id_i(req_id),
    .req_wdata_i(req_wdata), .priv_lvl_i(lvl), .mon_present_i(mon),
    .secure_i(sec), .sec_l2_en_i(sl2), .sec_timer_acc_i(stacc),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_syn_o(rsp_syn),
    .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] l, input logic wr, input logic [15:0] id, input logic [63:0] wd);
    @(negedge clk);
    lvl = l; req_valid = 1; req_write = wr; req_id = id; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    r_valid = rsp_valid; r_kind = rsp_kind; r_syn = rsp_syn; r_data = rsp_rdata;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    @(negedge clk);
    count = v;
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk);
    check(req, {63'd0, irq}, {63'd0, exp});
  endtask

  task automatic t_reset;
    check("R1 irq after reset", {63'd0, irq}, 64'd0);
    check("R1 no response after reset", {63'd0, rsp_valid}, 64'd0);
    acc(2'd3, 0, ID_CTL, '0);
    check("R1 ctrl reset (mask=1)", r_data, 64'h2);
    acc(2'd3, 0, ID_CMP, '0);
    check("R1 compare reset", r_data, 64'h0);
  endtask

  task automatic t_decode;
    acc(2'd3, 0, ID_BAD, '0);
    check("R2 unknown id undefined", {62'd0, r_kind}, 64'd1);
    check("R2 unknown id rdata", r_data, 64'd0);
    acc(2'd3, 0, ID_TV, '0);
    check("R2 tval id permitted", {62'd0, r_kind}, 64'd0);
    check("R6 response valid", {63'd0, r_valid}, 64'd1);
  endtask

  task automatic t_levels;
    acc(2'd0, 0, ID_CTL, '0);
    check("R3 level0 undefined", {62'd0, r_kind}, 64'd1);
    acc(2'd2, 0, ID_CTL, '0);
    check("R3 level2 undefined", {62'd0, r_kind}, 64'd1);
    acc(2'd3, 0, ID_CTL, '0);
    check("R3 level3 permitted", {62'd0, r_kind}, 64'd0);
  endtask

  task automatic t_level1;
    sec = 0;
    acc(2'd1, 0, ID_CTL, '0);
    check("R4 level1 nonsecure undefined", {62'd0, r_kind}, 64'd1);
    sec = 1; mon = 0;
    acc(2'd1, 0, ID_CTL, '0);
    check("R4 level1 no monitor undefined", {62'd0, r_kind}, 64'd1);
    mon = 1; sl2 = 1; stacc = 0;
    acc(2'd1, 0, ID_CTL, '0);
    check("R4 secure l2 wins over trap", {62'd0, r_kind}, 64'd1);
    sl2 = 0;
    acc(2'd1, 0, ID_CTL, '0);
    check("R4 trap kind", {62'd0, r_kind}, 64'd2);
    check("R6 trap syndrome", {58'd0, r_syn}, 64'h18);
    check("R5 trapped read rdata", r_data, 64'd0);
    stacc = 1;
    acc(2'd1, 0, ID_CTL, '0);
    check("R4 level1 permitted", {62'd0, r_kind}, 64'd0);
    check("R6 syndrome zero when permitted", {58'd0, r_syn}, 64'd0);
    check("R4 level1 read data", r_data, 64'h2);
  endtask

  task automatic t_blocked;
    stacc = 0;
    acc(2'd1, 1, ID_CMP, 64'h1234);
    stacc = 1;
    acc(2'd2, 1, ID_CTL, 64'h1);
    acc(2'd3, 0, ID_CMP, '0);
    check("R5 trapped write ignored", r_data, 64'd0);
    acc(2'd3, 0, ID_CTL, '0);
    check("R5 undefined write ignored", r_data, 64'h2);
  endtask

  task automatic t_cmp_full;
    acc(2'd3, 1, ID_CMP, 64'hA5A5_0000_5A5A_FFFF);
    check("R6 write rdata zero", r_data, 64'd0);
    acc(2'd3, 0, ID_CMP, '0);
    check("R12 compare 64-bit", r_data, 64'hA5A5_0000_5A5A_FFFF);
  endtask

  task automatic t_tval_read;
    acc(2'd3, 1, ID_CMP, 64'h1_0000_0100);
    set_cnt(64'h1_0000_0000);
    acc(2'd3, 0, ID_TV, '0);
    check("R7 tval positive", r_data, 64'h100);
    set_cnt(64'h1_0000_0200);
    acc(2'd3, 0, ID_TV, '0);
    check("R7 tval past, zero-extended", r_data, 64'hFFFF_FF00);
    set_cnt(64'h1_0000_0205);
    acc(2'd3, 0, ID_TV, '0);
    check("R7 tval falls while disabled", r_data, 64'hFFFF_FEFB);
  endtask

  task automatic t_tval_write;
    set_cnt(64'h20_0000_0000);
    acc(2'd3, 1, ID_TV, 64'hDEAD_BEEF_8000_0000);
    acc(2'd3, 0, ID_CMP, '0);
    check("R8 negative sign-extended, upper ignored", r_data, 64'h1F_8000_0000);
    acc(2'd3, 1, ID_TV, 64'hFFFF_FFFF_0000_0010);
    acc(2'd3, 0, ID_CMP, '0);
    check("R8 positive write", r_data, 64'h20_0000_0010);
  endtask

  task automatic t_condition;
    acc(2'd3, 1, ID_CTL, 64'h1);
    set_cnt(64'h20_0000_000F);
    chk_irq("R10 irq low before compare", 0);
    acc(2'd3, 0, ID_CTL, '0);
    check("R9 status clear before compare", r_data, 64'h1);
    set_cnt(64'h20_0000_0010);
    chk_irq("R10 irq high at compare", 1);
    acc(2'd3, 0, ID_CTL, '0);
    check("R9 status set at compare", r_data, 64'h5);
    acc(2'd3, 1, ID_CTL, 64'h3);
    chk_irq("R10 mask silences irq", 0);
    acc(2'd3, 0, ID_CTL, '0);
    check("R9 status set under mask", r_data, 64'h7);
    acc(2'd3, 1, ID_CTL, 64'h0);
    chk_irq("R10 irq low when disabled", 0);
    acc(2'd3, 0, ID_CTL, '0);
    check("R9 no condition when disabled", r_data, 64'h0);
    acc(2'd3, 1, ID_CMP, 64'h0);
    acc(2'd3, 1, ID_CTL, 64'h1);
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    chk_irq("R10 wrapped count no irq", 0);
    acc(2'd3, 0, ID_CTL, '0);
    check("R9 signed compare on wrap", r_data, 64'h1);
  endtask

  task automatic t_status_ro;
    acc(2'd3, 1, ID_CTL, 64'hFFFF_FFFF_FFFF_FFF4);
    acc(2'd3, 0, ID_CTL, '0);
    check("R11 status and upper write ignored", r_data, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_levels();
    t_level1();
    t_blocked();
    t_cmp_full();
    t_tval_read();
    t_tval_write();
    t_condition();
    t_status_ro();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule